// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block receives eight active-low interrupt request lines from outside the chip and turns them into a pending vector and a single combined interrupt request. Each line is either level-sensitive or falling-edge-sensitive, selected per line. A per-line wake enable lets a low level on that line raise a one-cycle wake pulse while the system sits in low-power mode. Every input goes through a two-stage synchroniser before detection takes place.

Software controls the block through a small register port with an address, a write strobe, write data and registered read data. Address 0 holds the 32-bit trigger configuration. Address 1 reads the pending vector, and a write to it clears pending bits for each data bit that is 1. A latched edge stays pending until software clears it. A level-triggered line simply tracks its synchronised input.

Top module: `irq_trig_ctl`

## Requirements
- R1: Address 0 is a read/write configuration word. Using MSB-first numbering (bit 0 = data bit 31), line n's edge-select sits at position 2n (data bit 31-2n) and its wake enable at position 2n+1 (data bit 30-2n). Read data appears one cycle after the address is presented.
- R2: Data bits 15:0 of the configuration word are reserved. Writes to them are ignored and they read back as 0.
- R3: After synchronous reset, the configuration word is 0, pend_o is 0, irq_o is 0 and wake_o is 0.
- R4: A line whose edge-select is 0 has its pending bit equal to the inverted synchronised input. The bit becomes visible 3 clock edges after the pin changes. A clear write has no effect on it while the line is low.
- R5: A line whose edge-select is 1 sets its pending bit 3 edges after a high-to-low transition. The bit remains set after the line returns high. Holding the line low does not set it again after a clear.
- R6: Writing address 1 clears pending bit n (data bit n) for each data bit n that is 1, effective at the write edge. Reading address 1 returns the pending vector in data bits 7:0 and 0 elsewhere.
- R7: When an edge is detected on a line in the same cycle that a clear of that line is written, the pending bit stays set.
- R8: irq_o equals the OR of pend_o as it stood one cycle earlier.
- R9: While low_power_i is 1, a low synchronised level on any line with wake enable 1 produces a one-cycle pulse on wake_o when that condition starts. A line with wake enable 0, or any line while low_power_i is 0, produces no pulse.
- R10: A configuration write that switches a line from level to edge mode clears that line's pending bit. A later falling edge is then needed to set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 8 | Active-low external request lines, asynchronous |
| low_power_i | input | 1 | System is in low-power mode |
| reg_addr_i | input | 2 | Register address: 0 configuration, 1 pending |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| pend_o | output | 8 | Pending vector, bit n for line n |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
Edge detection and the software clear can land on the same line in the same cycle. The bench first latches an edge on line 2 and lets the line return high. It then drives the line low again and times the clear write to hit the same edge at which the synchronised falling edge is detected, two cycles after the pin change. The scoreboard expects the pending bit to read 1 both right after that edge and several cycles later, and a second, isolated clear is then expected to drop it.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int unsigned LINES       = 8;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 2;
    localparam int unsigned SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_PEND = ADDR_W'(1);

    typedef struct packed {
        logic edge_mode;
        logic wake_en;
    } line_cfg_t;

    // Field positions in the configuration word (MSB-first pairs).
    function automatic int unsigned ed_bit(input int unsigned n);
        return DATA_W - 1 - 2 * n;
    endfunction

    function automatic int unsigned wm_bit(input int unsigned n);
        return DATA_W - 2 - 2 * n;
    endfunction

endpackage

// File: rtl/irqt_sync.sv
module irqt_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '1;
            end else begin
                if (s == 0) stg[s] <= async_i;
                else        stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/irqt_cfg.sv
module irqt_cfg
    import irqt_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [N-1:0]  ed_o,
    output logic [N-1:0]  wm_o,
    output logic [N-1:0]  ed_set_o,
    output logic [DW-1:0] word_o
);
    line_cfg_t [N-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < N; i++) begin
                cfg_q[i].edge_mode <= wdata_i[ed_bit(i)];
                cfg_q[i].wake_en   <= wdata_i[wm_bit(i)];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign ed_o[i]     = cfg_q[i].edge_mode;
        assign wm_o[i]     = cfg_q[i].wake_en;
        // level -> edge switch requested by this write
        assign ed_set_o[i] = wr_i & wdata_i[ed_bit(i)] & ~cfg_q[i].edge_mode;
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < N; i++) begin
            word_o[ed_bit(i)] = cfg_q[i].edge_mode;
            word_o[wm_bit(i)] = cfg_q[i].wake_en;
        end
    end
endmodule

// File: rtl/irqt_pend.sv
module irqt_pend #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_n_i,
    input  logic [N-1:0] ed_i,
    input  logic [N-1:0] ed_set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] edge_o,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= sync_n_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign edge_o[i] = prev_q[i] & ~sync_n_i[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[i] <= 1'b0;
            end else if (ed_set_i[i]) begin
                pend_o[i] <= edge_o[i];
            end else if (ed_i[i]) begin
                pend_o[i] <= edge_o[i] | (pend_o[i] & ~clr_i[i]);
            end else begin
                pend_o[i] <= ~sync_n_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_trig_ctl.sv
module irq_trig_ctl
    import irqt_pkg::*;
#(
    parameter int unsigned N  = irqt_pkg::LINES,
    parameter int unsigned DW = irqt_pkg::DATA_W,
    parameter int unsigned AW = irqt_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_n_i,
    input  logic          low_power_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic          reg_we_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic [N-1:0]  pend_o,
    output logic          irq_o,
    output logic          wake_o
);
    logic [N-1:0]  sync_n;
    logic [N-1:0]  ed, wm, ed_set, edge_evt, clr;
    logic [DW-1:0] cfg_word, pend_word;
    logic          cfg_wr, wake_cond, wake_q;

    assign cfg_wr = reg_we_i && (reg_addr_i == ADR_CFG);
    assign clr    = (reg_we_i && (reg_addr_i == ADR_PEND)) ? reg_wdata_i[N-1:0] : '0;

    irqt_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_n_i),
        .sync_o  (sync_n)
    );

    irqt_cfg #(.N(N), .DW(DW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cfg_wr),
        .wdata_i  (reg_wdata_i),
        .ed_o     (ed),
        .wm_o     (wm),
        .ed_set_o (ed_set),
        .word_o   (cfg_word)
    );

    irqt_pend #(.N(N)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .sync_n_i (sync_n),
        .ed_i     (ed),
        .ed_set_i (ed_set),
        .clr_i    (clr),
        .edge_o   (edge_evt),
        .pend_o   (pend_o)
    );

    always_comb begin
        pend_word        = '0;
        pend_word[N-1:0] = pend_o;
    end

    assign wake_cond = low_power_i & |(wm & ~sync_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata_o <= '0;
            irq_o       <= 1'b0;
            wake_q      <= 1'b0;
            wake_o      <= 1'b0;
        end else begin
            case (reg_addr_i)
                ADR_CFG:  reg_rdata_o <= cfg_word;
                ADR_PEND: reg_rdata_o <= pend_word;
                default:  reg_rdata_o <= '0;
            endcase
            irq_o  <= |pend_o;
            wake_q <= wake_cond;
            wake_o <= wake_cond & ~wake_q;
        end
    end
endmodule

// File: rtl/irqt_chk.sv
module irqt_chk
    import irqt_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  sync_n,
    input logic [N-1:0]  ed,
    input logic [N-1:0]  ed_set,
    input logic [N-1:0]  edge_evt,
    input logic [N-1:0]  clr,
    input logic [N-1:0]  pend,
    input logic          irq,
    input logic          wake,
    input logic          lp,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata
);
    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
        irq == (|$past(pend)));  // R8
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);  // R9
    AST_WAKE_NEEDS_LP: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(lp));  // R9
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(addr) == ADR_CFG) |-> (rdata[15:0] == 16'h0));  // R2

    for (genvar i = 0; i < N; i++) begin : g_line
        AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
            (!ed[i] && !ed_set[i]) |=> (pend[i] == !$past(sync_n[i])));  // R4
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ed[i] && pend[i] && !clr[i]) |=> (pend[i] || !ed[i]));  // R5
        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
            (ed[i] && edge_evt[i] && clr[i]) |=> pend[i]);  // R7
        AST_MODE_DISCARD: assert property (@(posedge clk) disable iff (rst)
            (ed_set[i] && !edge_evt[i]) |=> !pend[i]);  // R10
    end
endmodule

bind irq_trig_ctl irqt_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_n   (sync_n),
    .ed       (ed),
    .ed_set   (ed_set),
    .edge_evt (edge_evt),
    .clr      (clr),
    .pend     (pend_o),
    .irq      (irq_o),
    .wake     (wake_o),
    .lp       (low_power_i),
    .addr     (reg_addr_i),
    .rdata    (reg_rdata_o)
);

// File: tb/sim_irq_trig_ctl.sv
module sim_irq_trig_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  irq_n;
    logic        lp;
    logic [1:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  pend;
    logic        irq;
    logic        wake;

    irq_trig_ctl u0 (
        .clk         (clk),
        .rst         (rst),
        .irq_n_i     (irq_n),
        .low_power_i (lp),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pend_o      (pend),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // kinds: 0 pend bit, 1 irq, 2 wake, 3 read data, 4 whole pend vector
    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] val;
        int          due;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int kind, input int idx, input logic [31:0] v,
                             input int dly, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.val = v; it.due = cyc + dly; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    // monitor: pop and compare every item due this cycle
    always @(negedge clk) begin
        item_t keep[$];
        keep = {};
        foreach (sb[k]) begin
            if (sb[k].due == cyc) begin
                logic [31:0] act;
                case (sb[k].kind)
                    0:       act = {31'b0, pend[sb[k].idx]};
                    1:       act = {31'b0, irq};
                    2:       act = {31'b0, wake};
                    3:       act = rdata;
                    default: act = {24'b0, pend};
                endcase
                checks++;
                if (act !== sb[k].val) begin
                    failures++;
                    $display("FAIL %s kind=%0d idx=%0d cyc=%0d actual=%h expected=%h",
                             sb[k].tag, sb[k].kind, sb[k].idx, cyc, act, sb[k].val);
                end
            end else begin
                keep.push_back(sb[k]);
            end
        end
        sb = keep;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_n = 8'hFF; lp = 1'b0; addr = 2'd0; we = 1'b0; wdata = '0;
        step(3);
        rst = 1'b0;

        // R3 reset state
        addr = 2'd0;
        expect_at(4, 0, 32'h0, 1, "R3 pend");
        expect_at(1, 0, 32'h0, 1, "R3 irq");
        expect_at(2, 0, 32'h0, 1, "R3 wake");
        expect_at(3, 0, 32'h0, 1, "R3 cfg");
        step(2);

        // R4 level line 0, R8 combined request
        expect_at(0, 0, 32'h0, 2, "R4 latency");
        expect_at(0, 0, 32'h1, 3, "R4 set");
        expect_at(1, 0, 32'h0, 3, "R8 lag");
        expect_at(1, 0, 32'h1, 4, "R8 set");
        irq_n[0] = 1'b0;
        step(5);
        expect_at(0, 0, 32'h1, 1, "R4 clr ignored");
        expect_at(0, 0, 32'h1, 3, "R4 clr ignored");
        reg_write(2'd1, 32'h1);
        step(3);
        expect_at(0, 0, 32'h0, 3, "R4 release");
        expect_at(1, 0, 32'h0, 4, "R8 drop");
        irq_n[0] = 1'b1;
        step(5);

        // R1/R2 configuration: edge on lines 1,2, wake on line 3, reserved junk
        reg_write(2'd0, 32'h2900_FFFF);
        addr = 2'd0;
        expect_at(3, 0, 32'h2900_0000, 1, "R1 R2 readback");
        step(2);

        // R5 edge line 1
        expect_at(0, 1, 32'h1, 3, "R5 edge set");
        irq_n[1] = 1'b0;
        step(5);
        expect_at(0, 1, 32'h1, 3, "R5 sticky");
        irq_n[1] = 1'b1;
        step(5);
        addr = 2'd1;
        expect_at(3, 0, 32'h0000_0002, 1, "R6 read pend");
        step(2);
        expect_at(0, 1, 32'h0, 1, "R6 clear");
        reg_write(2'd1, 32'h2);
        step(2);
        expect_at(0, 1, 32'h1, 3, "R5 second edge");
        irq_n[1] = 1'b0;
        step(5);
        expect_at(0, 1, 32'h0, 1, "R5 clr held low");
        expect_at(0, 1, 32'h0, 4, "R5 no retrigger");
        reg_write(2'd1, 32'h2);
        step(5);
        irq_n[1] = 1'b1;
        step(4);

        // R7 edge and clear in the same cycle on line 2
        expect_at(0, 2, 32'h1, 3, "R7 prep");
        irq_n[2] = 1'b0;
        step(4);
        irq_n[2] = 1'b1;
        step(4);
        irq_n[2] = 1'b0;
        step(2);
        expect_at(0, 2, 32'h1, 1, "R7 edge wins");
        expect_at(0, 2, 32'h1, 3, "R7 stays");
        reg_write(2'd1, 32'h4);
        step(3);
        expect_at(0, 2, 32'h0, 1, "R6 plain clear");
        reg_write(2'd1, 32'h4);
        step(2);
        irq_n[2] = 1'b1;
        step(4);

        // R9 wake
        lp = 1'b0;
        expect_at(2, 0, 32'h0, 3, "R9 no lp");
        expect_at(2, 0, 32'h0, 4, "R9 no lp");
        irq_n[3] = 1'b0;
        step(5);
        expect_at(2, 0, 32'h1, 1, "R9 pulse");
        expect_at(2, 0, 32'h0, 2, "R9 pulse end");
        lp = 1'b1;
        step(4);
        irq_n[3] = 1'b1;
        step(5);
        expect_at(2, 0, 32'h0, 3, "R9 masked line");
        expect_at(2, 0, 32'h0, 4, "R9 masked line");
        irq_n[4] = 1'b0;
        step(5);
        irq_n[4] = 1'b1;
        lp = 1'b0;
        step(5);

        // R10 level -> edge discards pending on line 5
        expect_at(0, 5, 32'h1, 3, "R10 level set");
        irq_n[5] = 1'b0;
        step(5);
        expect_at(0, 5, 32'h0, 1, "R10 discard");
        expect_at(0, 5, 32'h0, 4, "R10 still clear");
        reg_write(2'd0, 32'h2920_0000);
        step(5);
        irq_n[5] = 1'b1;
        step(4);
        expect_at(0, 5, 32'h1, 3, "R10 new edge");
        irq_n[5] = 1'b0;
        step(6);

        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule